// File: doc/BRIEF.md
# Windowed Bitmap Nonzero Scanner

This block walks a wide row bitmap and hands out, one request at a time, the column numbers of its set bits in ascending order. A row is loaded as a 512-bit bitmap together with a row length. Bits at or above that length are dropped when the row is loaded. Each accepted request then yields the lowest remaining set column, and that bit is cleared so it is never given out again. A caller uses each returned column as the index of the next nonzero value of the row. A row with k set bits below its length therefore takes exactly k detections.

The scanner looks at the bitmap one 32-bit window at a time. A single-cycle leading-one detector finds the lowest set bit of the current window. An empty window costs one cycle, and the scan pointer then moves to the following window. When the last window has been searched and nothing is left, the block raises an end-of-row flag. That flag holds until the next load.

The control is a three-state machine. `ST_WAIT` waits for a request with `rdy_o` high. `ST_SCAN` searches windows. `ST_END` holds the end-of-row flag. The transitions are:
- `T_ACCEPT`: `ST_WAIT` to `ST_SCAN` on `next_i`.
- `T_HIT`: `ST_SCAN` to `ST_WAIT` when the window holds a set bit.
- `T_SKIP`: `ST_SCAN` to `ST_SCAN` on an empty window that is not the last.
- `T_EXHAUST`: `ST_SCAN` to `ST_END` on an empty last window.
- `T_LOAD`: any state to `ST_WAIT` on `load_i`.

Top module: `bmp_nz_scanner`

## Requirements
- R1: After reset `rdy_o` is 1, `pos_vld_o` is 0 and `eor_o` is 0, and the held bitmap is empty.
- R2: Successive positions reported after one load are strictly increasing. Each set bit kept at load is reported exactly once.
- R3: A request accepted at clock edge E (`next_i` high while `rdy_o` is 1), whose lowest remaining set bit lies in the current window, gives `pos_vld_o` high for exactly one cycle after edge E+1. `rdy_o` is high again in that same cycle.
- R4: Each all-zero window between the current window and the window of the next set bit adds exactly one cycle. A hit in window t, searched from window w, gives `pos_vld_o` after edge E+(t-w)+1.
- R5: `pos_o` is 9 bits: the window index (0 to 15) in bits 8:5 and the offset in the window (0 to 31) in bits 4:0. This value equals the column number of the bit.
- R6: Bits at column `load_len_i` and above are never reported. `load_len_i` is 10 bits wide, so 0 keeps no bits and 512 keeps all.
- R7: When no set bits remain, a request searches the windows from the current one (w) through window 15. `eor_o` rises after edge E+(16-w) and stays 1 with `rdy_o` 0 until the next load. `pos_vld_o` and `eor_o` are never both 1.
- R8: `load_i` takes priority over everything else. After the load edge, `rdy_o` is 1, `eor_o` is 0 and the scan restarts at window 0. No result of an earlier row appears after that edge.
- R9: `next_i` has no effect while `rdy_o` is 0, either during a search or after end of row.
- R10: The number of `pos_vld_o` pulses between a load and `eor_o` equals the number of set bits in the loaded bitmap below `load_len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new row bitmap and length |
| load_bmp_i | input | 512 | Row bitmap, bit i is column i |
| load_len_i | input | 10 | Row length; columns at or above it are ignored |
| next_i | input | 1 | Request the next set column |
| rdy_o | output | 1 | Scanner idle and accepting a request |
| pos_o | output | 9 | Column of the reported set bit |
| pos_vld_o | output | 1 | One-cycle pulse: `pos_o` is valid |
| eor_o | output | 1 | End of row, no set bits remain |

## Verification
A hit is due 1 + (t - w) cycles after the accepting edge, and end of row is due 16 - w cycles after it. Both depend on which window the pointer sits in and which window holds the next bit. The bench's reference model works out each of these delays when the request is accepted. It then counts the delay down, so `rdy_o`, `pos_vld_o`, `eor_o` and `pos_o` are predicted for every cycle. The bench compares the model and the outputs at the falling edge after each rising edge. Two directed cases measure the delay directly: one with a hit in the first window, one with a hit in the last window.

// File: rtl/bmp_scan_pkg.sv
package bmp_scan_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_SCAN = 2'd1,
        ST_END  = 2'd2
    } scan_state_t;

endpackage

// File: rtl/bmp_len_mask.sv
module bmp_len_mask #(
    parameter int BMP_W = 512,
    parameter int LEN_W = 10
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [BMP_W-1:0] keep_o
);

    for (genvar g = 0; g < BMP_W; g++) begin : g_keep
        assign keep_o[g] = (LEN_W'(g) < len_i);
    end

endmodule

// File: rtl/bmp_win_lnzd.sv
module bmp_win_lnzd #(
    parameter int WIN_W = 32,
    localparam int OFF_W = $clog2(WIN_W)
) (
    input  logic [WIN_W-1:0] win_i,
    output logic             hit_o,
    output logic [OFF_W-1:0] off_o
);

    always_comb begin
        hit_o = |win_i;
        off_o = '0;
        for (int i = WIN_W - 1; i >= 0; i--) begin
            if (win_i[i]) begin
                off_o = OFF_W'(i);
            end
        end
    end

endmodule

// File: rtl/bmp_nz_scanner.sv
module bmp_nz_scanner
    import bmp_scan_pkg::*;
#(
    parameter int BMP_W = 512,
    parameter int WIN_W = 32,
    localparam int POS_W = $clog2(BMP_W),
    localparam int LEN_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BMP_W-1:0] load_bmp_i,
    input  logic [LEN_W-1:0] load_len_i,
    input  logic             next_i,
    output logic             rdy_o,
    output logic [POS_W-1:0] pos_o,
    output logic             pos_vld_o,
    output logic             eor_o
);

    localparam int OFF_W  = $clog2(WIN_W);
    localparam int N_WIN  = BMP_W / WIN_W;
    localparam int WIX_W  = POS_W - OFF_W;
    localparam logic [WIX_W-1:0] LAST_WIN = WIX_W'(N_WIN - 1);
    localparam logic [BMP_W-1:0] ONE_BIT  = BMP_W'(1);

    scan_state_t       state_q, state_d;
    logic [BMP_W-1:0]  bits_q;
    logic [WIX_W-1:0]  win_q;
    logic [POS_W-1:0]  pos_q;
    logic              vld_q;
    logic              eor_q;

    logic [BMP_W-1:0]  keep;
    logic [WIN_W-1:0]  cur_win;
    logic              win_hit;
    logic [OFF_W-1:0]  win_off;
    logic [POS_W-1:0]  hit_pos;

    bmp_len_mask #(
        .BMP_W (BMP_W),
        .LEN_W (LEN_W)
    ) u_mask (
        .len_i  (load_len_i),
        .keep_o (keep)
    );

    assign cur_win = bits_q[win_q*WIN_W +: WIN_W];

    bmp_win_lnzd #(
        .WIN_W (WIN_W)
    ) u_lnzd (
        .win_i (cur_win),
        .hit_o (win_hit),
        .off_o (win_off)
    );

    assign hit_pos = {win_q, win_off};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_WAIT;                       // T_LOAD
        end else begin
            unique case (state_q)
                ST_WAIT: if (next_i) state_d = ST_SCAN;            // T_ACCEPT
                ST_SCAN: begin
                    if (win_hit)               state_d = ST_WAIT;  // T_HIT
                    else if (win_q == LAST_WIN) state_d = ST_END;  // T_EXHAUST
                    else                       state_d = ST_SCAN;  // T_SKIP
                end
                ST_END:  state_d = ST_END;
                default: state_d = ST_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            win_q  <= '0;
            pos_q  <= '0;
            vld_q  <= 1'b0;
            eor_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (load_i) begin
                bits_q <= load_bmp_i & keep;
                win_q  <= '0;
                eor_q  <= 1'b0;
            end else if (state_q == ST_SCAN) begin
                if (win_hit) begin
                    pos_q  <= hit_pos;
                    vld_q  <= 1'b1;
                    bits_q <= bits_q & ~(ONE_BIT << hit_pos);
                end else if (win_q == LAST_WIN) begin
                    eor_q  <= 1'b1;
                end else begin
                    win_q  <= win_q + 1'b1;
                end
            end
        end
    end

    assign rdy_o     = (state_q == ST_WAIT);
    assign pos_o     = pos_q;
    assign pos_vld_o = vld_q;
    assign eor_o     = eor_q;

endmodule

// File: rtl/bmp_nz_scanner_chk.sv
module bmp_nz_scanner_chk #(
    parameter int POS_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             rdy_o,
    input logic [POS_W-1:0] pos_o,
    input logic             pos_vld_o,
    input logic             eor_o
);

    logic [POS_W-1:0] prev_pos;
    logic             have_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_pos  <= '0;
            have_prev <= 1'b0;
        end else if (load_i) begin
            have_prev <= 1'b0;
        end else if (pos_vld_o) begin
            prev_pos  <= pos_o;
            have_prev <= 1'b1;
        end
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) pos_vld_o |=> !pos_vld_o); // R3
    AST_VLD_WITH_RDY:  assert property (@(posedge clk) disable iff (!rst_n) pos_vld_o |-> rdy_o); // R3
    AST_ASCENDING:     assert property (@(posedge clk) disable iff (!rst_n) (pos_vld_o && have_prev && !load_i) |-> (pos_o > prev_pos)); // R2
    AST_EOR_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (eor_o && !load_i) |=> eor_o); // R7
    AST_EOR_NOT_RDY:   assert property (@(posedge clk) disable iff (!rst_n) eor_o |-> !rdy_o); // R7
    AST_VLD_EOR_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(pos_vld_o && eor_o)); // R7
    AST_LOAD_RESTART:  assert property (@(posedge clk) disable iff (!rst_n) load_i |=> (rdy_o && !eor_o && !pos_vld_o)); // R8

endmodule

bind bmp_nz_scanner bmp_nz_scanner_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .rdy_o     (rdy_o),
    .pos_o     (pos_o),
    .pos_vld_o (pos_vld_o),
    .eor_o     (eor_o)
);

// File: tb/bmp_nz_scanner_tb.sv
module bmp_nz_scanner_tb;

    localparam int BW = 512;
    localparam int WW = 32;
    localparam int NW = BW / WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [BW-1:0] load_bmp_i = '0;
    logic [9:0]    load_len_i = '0;
    logic          next_i = 1'b0;
    logic          rdy_o, pos_vld_o, eor_o;
    logic [8:0]    pos_o;

    int total = 0;
    int bad = 0;
    int got_q[$];

    always #2 clk = ~clk;   // 250 MHz

    bmp_nz_scanner u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .load_bmp_i (load_bmp_i),
        .load_len_i (load_len_i),
        .next_i     (next_i),
        .rdy_o      (rdy_o),
        .pos_o      (pos_o),
        .pos_vld_o  (pos_vld_o),
        .eor_o      (eor_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model: delay to the result is worked out when a request is accepted
    logic [BW-1:0] m_bits = '0;
    int  m_win = 0;
    bit  m_rdy = 1'b1;
    int  m_cnt = 0;
    bit  m_res_eor = 1'b0;
    int  m_res_pos = 0;
    bit  e_vld = 1'b0;
    bit  e_eor = 1'b0;
    int  e_pos = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bits = '0; m_win = 0; m_rdy = 1'b1; m_cnt = 0;
            e_vld = 1'b0; e_eor = 1'b0;
        end else begin
            e_vld = 1'b0;
            if (load_i) begin
                for (int i = 0; i < BW; i++) m_bits[i] = load_bmp_i[i] && (i < int'(load_len_i));
                m_win = 0; m_rdy = 1'b1; m_cnt = 0; e_eor = 1'b0;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_res_eor) e_eor = 1'b1;
                    else begin e_vld = 1'b1; e_pos = m_res_pos; m_rdy = 1'b1; end
                end
            end else if (m_rdy && next_i) begin
                int p;
                p = -1;
                for (int i = BW - 1; i >= 0; i--) if (m_bits[i]) p = i;
                m_rdy = 1'b0;
                if (p < 0) begin
                    m_res_eor = 1'b1; m_cnt = NW - m_win;
                end else begin
                    m_res_eor = 1'b0; m_res_pos = p;
                    m_cnt = p / WW - m_win + 1;
                    m_win = p / WW;
                    m_bits[p] = 1'b0;
                end
            end
        end
    end

    // per-cycle comparison, half a period after each rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R9", "rdy_o", int'(rdy_o), int'(m_rdy));
            check("R3", "pos_vld_o", int'(pos_vld_o), int'(e_vld));
            check("R7", "eor_o", int'(eor_o), int'(e_eor));
            if (e_vld) check("R5", "pos_o", int'(pos_o), e_pos);
            if (pos_vld_o) got_q.push_back(int'(pos_o));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic do_load(input logic [BW-1:0] b, input int len);
        @(negedge clk);
        load_bmp_i = b; load_len_i = 10'(len); load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        got_q.delete();
    endtask

    task automatic drain(input bit hold);
        for (int k = 0; k < 20000 && !eor_o; k++) begin
            @(negedge clk);
            next_i = hold ? 1'b1 : (rdy_o && (k % 3 == 0));
        end
        @(negedge clk);
        next_i = 1'b0;
    endtask

    task automatic check_list(input logic [BW-1:0] b, input int len, input string tag);
        int exp_q[$];
        for (int i = 0; i < BW; i++) if (b[i] && i < len) exp_q.push_back(i);
        check("R10", {tag, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check("R2", {tag, " order"}, got_q[i], exp_q[i]);
    endtask

    task automatic measure(input int expect_n, input string req);
        int n;
        @(negedge clk);
        next_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            next_i = 1'b0;
            n++;
        end while (!pos_vld_o && !eor_o && n < 40);
        check(req, "latency", n, expect_n);
    endtask

    initial begin
        logic [BW-1:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset rdy_o", int'(rdy_o), 1);
        check("R1", "reset pos_vld_o", int'(pos_vld_o), 0);
        check("R1", "reset eor_o", int'(eor_o), 0);

        // R2 R5 R10: spread bits, full length
        b = '0; b[0] = 1; b[1] = 1; b[31] = 1; b[32] = 1; b[100] = 1; b[511] = 1;
        do_load(b, 512); drain(1'b0); check_list(b, 512, "spread");

        // R3: hit in current window
        b = '0; b[3] = 1; do_load(b, 512);
        measure(2, "R3");
        // R4: 15 empty windows then a hit in the last
        b = '0; b[480] = 1; do_load(b, 512);
        measure(17, "R4");

        // R6: bits at and above the length are dropped
        b = '0; b[5] = 1; b[249] = 1; b[250] = 1; b[300] = 1;
        do_load(b, 250); drain(1'b1); check_list(b, 250, "R6 len250");
        do_load({BW{1'b1}}, 0); drain(1'b0);
        check("R6", "len0 count", got_q.size(), 0);

        // R7: empty row reaches end of row; R9: requests after end are ignored
        do_load('0, 512); drain(1'b0);
        repeat (4) begin @(negedge clk); next_i = 1'b1; end
        @(negedge clk); next_i = 1'b0;
        check("R9", "no pulse after end", got_q.size(), 0);
        check("R7", "eor held", int'(eor_o), 1);

        // R8: reload during a search
        b = '0; b[400] = 1; do_load(b, 512);
        @(negedge clk); next_i = 1'b1;
        @(negedge clk); next_i = 1'b0;
        repeat (3) @(negedge clk);
        b = '0; b[7] = 1; b[70] = 1;
        do_load(b, 512);
        check("R8", "rdy after reload", int'(rdy_o), 1);
        check("R8", "eor after reload", int'(eor_o), 0);
        drain(1'b1); check_list(b, 512, "R8 reload");

        // pseudo-random sparse rows
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < NW; w++) b[w*WW +: WW] = $urandom & $urandom & $urandom;
            do_load(b, 64 + r * 90);
            drain(r[0]);
            check_list(b, 64 + r * 90, "R10 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule